// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block is a small register-mapped arithmetic engine for unsigned integers. Software writes operand bytes through a single write port, selected by a three-bit register code. Two of the codes are triggers. Writing the second multiplicand runs an 8x8 multiply. Writing the divisor runs a 16/8 divide. The block produces one result bit per clock. A multiply finishes in 8 cycles and a divide in 16.

Results come out on two registered outputs. `quotient` carries the divide quotient. `prod_rem` is shared: it holds the product after a multiply and the remainder after a divide. Neither output changes while an operation runs. The first multiplicand and the dividend are held between operations. Because of this, a series of products with the same left operand needs only one byte written for each product. A trigger that arrives while an operation is still running abandons that operation and starts the new one.

Top module: `muldiv_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0 and `quotient` and `prod_rem` are 0. The first multiplicand holds 0xFF and the dividend holds 0xFFFF, so a trigger written with no operand writes first uses these values.
- R2: A write with `wr_sel` = 1 starts an unsigned multiply of the held first multiplicand by `wr_data`. The 16-bit product appears on `prod_rem` at the eighth rising edge after the write edge. A multiply leaves `quotient` unchanged.
- R3: A write with `wr_sel` = 4 starts an unsigned divide of the held dividend by `wr_data`. The quotient and the remainder (zero-extended to 16 bits) appear at the sixteenth rising edge after the write edge.
- R4: A write with `wr_sel` = 0 loads the first multiplicand. No operation changes it, so further writes with `wr_sel` = 1 alone reuse it.
- R5: A divisor of zero yields a `quotient` of 0xFFFF and a `prod_rem` equal to the dividend.
- R6: `busy` rises after the trigger edge and stays high for exactly the latency of the operation, which is 8 cycles for a multiply and 16 for a divide.
- R7: `quotient` and `prod_rem` change only at the edge where an operation completes. They hold their values while the unit is busy and while it is idle.
- R8: A trigger that arrives while the unit is busy cancels the running operation. The cancelled operation produces no result. The new operation completes a full latency after its own trigger.
- R9: Operands are captured at the trigger edge, so operand writes during an operation do not affect its result. Writes with `wr_sel` 5, 6 or 7 have no effect.
- R10: The dividend is loaded one byte at a time: `wr_sel` = 2 writes bits 7:0 and `wr_sel` = 3 writes bits 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 3 | Register code for the write |
| wr_data | input | 8 | Write data byte |
| busy | output | 1 | An operation is in progress |
| quotient | output | 16 | Quotient of the last divide |
| prod_rem | output | 16 | Product of the last multiply, or remainder of the last divide |

## Verification
The hardest case to reach is a trigger that lands on a running operation, especially at the same edge where the old operation would have completed. At that edge the abandoned result must not appear. The bench reaches this case with directed retriggers at fixed offsets. It also runs a long random phase in which the gaps between writes are often shorter than the latency. During that phase, a behavioural countdown model predicts `busy`, `quotient` and `prod_rem`, and the bench compares all three on every cycle.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the multiply/divide unit.
// Assumes a three-bit register code on the write port.
package muldiv_pkg;
    typedef enum logic [2:0] {
        SEL_MUL_A  = 3'd0,
        SEL_MUL_B  = 3'd1,
        SEL_DVD_LO = 3'd2,
        SEL_DVD_HI = 3'd3,
        SEL_DVS    = 3'd4
    } reg_sel_e;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } op_kind_e;
endpackage

// File: rtl/muldiv_regs.sv
`timescale 1ns/1ps
// Operand register file and trigger decode.
// Holds the first multiplicand (reset 0xFF) and the dividend (reset 0xFFFF).
// The trigger registers carry no state of their own: their data goes
// straight to the engines as a go strobe.
module muldiv_regs
    import muldiv_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [OP_W-1:0]   wr_data,
    output logic [OP_W-1:0]   mcand_a,
    output logic [2*OP_W-1:0] dividend,
    output logic              mul_go,
    output logic              div_go
);
    // Decode the two trigger codes.
    assign mul_go = wr_en && (wr_sel == SEL_MUL_B);
    assign div_go = wr_en && (wr_sel == SEL_DVS);

    // Store the operand bytes; unknown codes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_a  <= '1;
            dividend <= '1;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_MUL_A:  mcand_a               <= wr_data;
                SEL_DVD_LO: dividend[OP_W-1:0]    <= wr_data;
                SEL_DVD_HI: dividend[2*OP_W-1:OP_W] <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/muldiv_seq.sv
`timescale 1ns/1ps
// Step sequencer: counts the iterations of the running operation.
// A new go always wins over a step, which aborts the running operation.
// finish pulses during the cycle whose edge performs the last step.
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mul_go,
    input  logic     div_go,
    output logic     busy,
    output logic     step_en,
    output logic     finish,
    output op_kind_e kind
);
    localparam int MUL_LAT = OP_W;
    localparam int DIV_LAT = 2 * OP_W;
    localparam int CW      = $clog2(DIV_LAT + 1);

    logic [CW-1:0] cnt;
    logic          go;

    assign go      = mul_go || div_go;
    assign step_en = busy && !go;
    assign finish  = step_en && (cnt == CW'(1));

    // Load the latency on go, count down one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
            kind <= OP_MUL;
        end else if (go) begin
            cnt  <= div_go ? CW'(DIV_LAT) : CW'(MUL_LAT);
            busy <= 1'b1;
            kind <= div_go ? OP_DIV : OP_MUL;
        end else if (step_en) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/muldiv_mul_engine.sv
`timescale 1ns/1ps
// Shift-and-add multiplier, one multiplier bit per step.
// Assumes load and step are never active together.
// prod_next is the accumulator value after the current step.
module muldiv_mul_engine #(
    parameter int OP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [2*OP_W-1:0] prod_next
);
    logic [2*OP_W-1:0] acc;
    logic [2*OP_W-1:0] mcand;
    logic [OP_W-1:0]   mplier;

    // Add the shifted multiplicand when the current multiplier bit is set.
    assign prod_next = acc + (mplier[0] ? mcand : '0);

    // Capture operands on load, advance one bit on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            mcand  <= '0;
            mplier <= '0;
        end else if (load) begin
            acc    <= '0;
            mcand  <= {{OP_W{1'b0}}, op_a};
            mplier <= op_b;
        end else if (step) begin
            acc    <= prod_next;
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
        end
    end
endmodule

// File: rtl/muldiv_div_engine.sv
`timescale 1ns/1ps
// Restoring divider, one quotient bit per step, MSB first.
// Valid for a non-zero divisor only; the top level overrides the zero case.
// Outputs show the quotient and remainder after the current step.
module muldiv_div_engine #(
    parameter int OP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [2*OP_W-1:0] dividend,
    input  logic [OP_W-1:0]   divisor,
    output logic [2*OP_W-1:0] quot_next,
    output logic [OP_W-1:0]   rem_next
);
    logic [OP_W-1:0]   rem;
    logic [2*OP_W-1:0] q;
    logic [OP_W-1:0]   dvs;
    logic [OP_W:0]     trial;
    logic [OP_W-1:0]   diff;
    logic              fits;

    // Trial subtract of the divisor from the partial remainder.
    always_comb begin
        trial     = {rem, q[2*OP_W-1]};
        fits      = trial >= {1'b0, dvs};
        diff      = trial[OP_W-1:0] - dvs;
        rem_next  = fits ? diff : trial[OP_W-1:0];
        quot_next = {q[2*OP_W-2:0], fits};
    end

    // Capture operands on load, produce one quotient bit on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            q   <= '0;
            dvs <= '0;
        end else if (load) begin
            rem <= '0;
            q   <= dividend;
            dvs <= divisor;
        end else if (step) begin
            rem <= rem_next;
            q   <= quot_next;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
// Top of the sequential unsigned multiply/divide unit.
// The write port loads operands. Codes 1 and 4 start a multiply or a divide.
// The result registers load only when an operation completes.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [OP_W-1:0]   wr_data,
    output logic              busy,
    output logic [2*OP_W-1:0] quotient,
    output logic [2*OP_W-1:0] prod_rem
);
    logic [OP_W-1:0]   mcand_a;
    logic [2*OP_W-1:0] dividend;
    logic              mul_go, div_go, step_en, finish;
    op_kind_e          kind;
    logic [2*OP_W-1:0] prod_next, quot_next;
    logic [OP_W-1:0]   rem_next;
    logic              dz_q;
    logic [2*OP_W-1:0] dvd_snap;

    muldiv_regs #(.OP_W(OP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .mcand_a(mcand_a), .dividend(dividend),
        .mul_go(mul_go), .div_go(div_go)
    );

    muldiv_seq #(.OP_W(OP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .mul_go(mul_go), .div_go(div_go),
        .busy(busy), .step_en(step_en), .finish(finish), .kind(kind)
    );

    muldiv_mul_engine #(.OP_W(OP_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(mul_go),
        .step(step_en && (kind == OP_MUL)),
        .op_a(mcand_a), .op_b(wr_data), .prod_next(prod_next)
    );

    muldiv_div_engine #(.OP_W(OP_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(div_go),
        .step(step_en && (kind == OP_DIV)),
        .dividend(dividend), .divisor(wr_data),
        .quot_next(quot_next), .rem_next(rem_next)
    );

    // Remember the zero-divisor case and the dividend it must return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dz_q     <= 1'b0;
            dvd_snap <= '0;
        end else if (div_go) begin
            dz_q     <= (wr_data == '0);
            dvd_snap <= dividend;
        end
    end

    // Load the visible results at the completing edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient <= '0;
            prod_rem <= '0;
        end else if (finish) begin
            if (kind == OP_MUL) begin
                prod_rem <= prod_next;
            end else if (dz_q) begin
                quotient <= '1;
                prod_rem <= dvd_snap;
            end else begin
                quotient <= quot_next;
                prod_rem <= {{OP_W{1'b0}}, rem_next};
            end
        end
    end
endmodule

// File: rtl/muldiv_checker.sv
`timescale 1ns/1ps
// Property checker for muldiv_unit, attached by bind.
// Follows the triggers with its own cycle counter to check latency.
module muldiv_checker
    import muldiv_pkg::*;
#(
    parameter int OP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [OP_W-1:0]   wr_data,
    input logic              busy,
    input logic [2*OP_W-1:0] quotient,
    input logic [2*OP_W-1:0] prod_rem
);
    localparam int CW = $clog2(2 * OP_W + 2) + 1;

    logic          trig, trig_div;
    logic [CW-1:0] c_cnt, c_tgt;
    logic          c_div, c_zero;

    assign trig_div = wr_en && (wr_sel == SEL_DVS);
    assign trig     = trig_div || (wr_en && (wr_sel == SEL_MUL_B));

    // Count the cycles since the last trigger while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_cnt  <= '0;
            c_tgt  <= '0;
            c_div  <= 1'b0;
            c_zero <= 1'b0;
        end else if (trig) begin
            c_cnt  <= '0;
            c_tgt  <= trig_div ? CW'(2 * OP_W) : CW'(OP_W);
            c_div  <= trig_div;
            c_zero <= (wr_data == '0);
        end else if (busy) begin
            c_cnt <= c_cnt + CW'(1);
        end
    end

    AST_BUSY_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> busy); // R6
    AST_LATENCY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (c_cnt == c_tgt)); // R6
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(quotient) && $stable(prod_rem))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !trig) |=> (!busy && $stable(quotient) && $stable(prod_rem))); // R7
    AST_MUL_KEEPS_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !c_div) |-> $stable(quotient)); // R2
    AST_DIV_ZERO_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && c_div && c_zero) |-> (quotient == '1)); // R5
endmodule

bind muldiv_unit muldiv_checker #(.OP_W(OP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .busy(busy), .quotient(quotient), .prod_rem(prod_rem)
);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
// Bench for muldiv_unit: a behavioural countdown model compared every cycle,
// plus directed checks on latency, corner values and retriggers.
module tb_muldiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        busy;
    logic [15:0] quotient, prod_rem;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit model_on = 0;

    // Reference model state.
    int m_a, m_dvd, m_cnt, m_q, m_pr, m_pq, m_ppr;
    bit m_keepq;

    always #2.5 clk = ~clk;

    muldiv_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy(busy), .quotient(quotient), .prod_rem(prod_rem)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model: a trigger restarts the countdown, otherwise it counts to completion.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 255; m_dvd = 65535; m_cnt = 0; m_q = 0; m_pr = 0;
        end else begin
            bit trig;
            trig = wr_en && (wr_sel == 3'd1 || wr_sel == 3'd4);
            if (!trig && m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (!m_keepq) m_q = m_pq;
                    m_pr = m_ppr;
                end
            end
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_a = wr_data;
                    3'd1: begin m_cnt = 8; m_keepq = 1; m_ppr = m_a * wr_data; end
                    3'd2: m_dvd = (m_dvd & 16'hFF00) | wr_data;
                    3'd3: m_dvd = (m_dvd & 16'h00FF) | (int'(wr_data) << 8);
                    3'd4: begin
                        m_cnt = 16; m_keepq = 0;
                        if (wr_data == 0) begin m_pq = 16'hFFFF; m_ppr = m_dvd; end
                        else begin m_pq = m_dvd / wr_data; m_ppr = m_dvd % wr_data; end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Compare the model with the outputs away from the clock edge.
    always @(negedge clk) begin
        if (model_on) begin
            chk("R6 busy vs model", busy, (m_cnt > 0));
            chk("R7 quotient vs model", quotient, m_q);
            chk("R7 prod_rem vs model", prod_rem, m_pr);
        end
    end

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Trigger and check busy across the latency, then the results.
    task automatic run(input logic [2:0] s, input logic [7:0] d, input int lat,
                       input string tag, input logic [15:0] eq, input logic [15:0] epr);
        wr(s, d);
        chk({tag, " busy after trigger R6"}, busy, 1'b1);
        repeat (lat - 1) @(negedge clk);
        chk({tag, " busy at last step R6"}, busy, 1'b1);
        @(negedge clk);
        chk({tag, " busy cleared R6"}, busy, 1'b0);
        chk({tag, " quotient"}, quotient, eq);
        chk({tag, " prod_rem"}, prod_rem, epr);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset busy", busy, 1'b0);
        chk("R1 reset quotient", quotient, 16'h0);
        chk("R1 reset prod_rem", prod_rem, 16'h0);
        rst_n = 1'b1;
        model_on = 1;

        run(3'd1, 8'd3, 8, "R1 R2 reset A times 3", 16'h0, 16'd765);
        run(3'd4, 8'd7, 16, "R1 R3 reset dividend div 7", 16'd9362, 16'd1);
        wr(3'd0, 8'hC8);
        run(3'd1, 8'hFA, 8, "R2 200x250", 16'd9362, 16'd50000);
        run(3'd1, 8'hFF, 8, "R4 A reused 200x255", 16'd9362, 16'd51000);
        wr(3'd2, 8'h34); wr(3'd3, 8'h12);
        run(3'd4, 8'h25, 16, "R10 R3 0x1234 div 37", 16'd125, 16'd35);
        run(3'd4, 8'h00, 16, "R5 divide by zero", 16'hFFFF, 16'h1234);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        run(3'd4, 8'h01, 16, "R3 0xFFFF div 1", 16'hFFFF, 16'h0);
        run(3'd4, 8'hFF, 16, "R3 0xFFFF div 255", 16'd257, 16'h0);
        wr(3'd0, 8'hFF);
        run(3'd1, 8'hFF, 8, "R2 max product", 16'd257, 16'hFE01);

        // R8: restart mid-multiply, then a divide that cuts into a multiply.
        wr(3'd0, 8'd10);
        wr(3'd1, 8'd2);
        repeat (2) @(negedge clk);
        run(3'd1, 8'd5, 8, "R8 mul restart", 16'd257, 16'd50);
        wr(3'd2, 8'd100); wr(3'd3, 8'd0);
        wr(3'd1, 8'd9);
        run(3'd4, 8'd7, 16, "R8 div over mul", 16'd14, 16'd2);
        // R8: retrigger on the edge that would have completed the multiply.
        wr(3'd1, 8'd4);
        repeat (6) @(negedge clk);
        run(3'd1, 8'd6, 8, "R8 retrigger at completion edge", 16'd14, 16'd60);

        // R9: operand writes during a run are not used.
        wr(3'd1, 8'd3);
        wr(3'd0, 8'd1);
        repeat (6) @(negedge clk);
        chk("R9 mul uses captured A", prod_rem, 16'd30);
        wr(3'd4, 8'd9);
        wr(3'd2, 8'd1);
        repeat (15) @(negedge clk);
        chk("R9 div uses captured dividend q", quotient, 16'd11);
        chk("R9 div uses captured dividend r", prod_rem, 16'd1);
        // R9: unknown codes leave everything alone.
        wr(3'd5, 8'h77); wr(3'd6, 8'h00); wr(3'd7, 8'hAA);
        chk("R9 unknown codes busy", busy, 1'b0);
        chk("R9 unknown codes quotient", quotient, 16'd11);
        run(3'd1, 8'd7, 8, "R9 A unchanged by unknown codes", 16'd11, 16'd7);

        // Random phase with short gaps, checked by the model.
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_sel = 3'($urandom_range(0, 7));
            wr_data = ($urandom_range(0, 5) == 0) ? 8'd0 : 8'($urandom);
            @(negedge clk);
            wr_en = 1'b0;
            repeat ($urandom_range(0, 20)) @(negedge clk);
        end
        repeat (20) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule